// File: doc/BRIEF.md
# Conversion-Ratio Meter and Anti-Alias Filter Picker

This block sits in front of an asynchronous sample-rate converter and works out how fast the incoming audio word clock runs compared with the local output sample rate. The local output rate is not a separate clock. It is the master clock divided by a fixed number of cycles, 512 by default. The block counts rising edges of the input word clock over a fixed window of output sample periods. At the end of each window it publishes the count as a ratio estimate. It also picks one of six anti-aliasing filter modes for the downstream filter engine.

The published count equals fsi/fso scaled by the window length. The window length is 2^WIN_LOG2 output periods, so the count reads directly as a fixed-point value with WIN_LOG2 fractional bits. The filter mode is found by comparing the count against five limits. Each limit is the window length divided by one of the conversion-ratio thresholds, and all five thresholds are exact fractions 32/33, 32/37, 32/45, 32/51 and 32/65. Measurement runs again in every window, so the outputs follow slow changes in either rate. A synchronous reset restarts the window and withdraws the valid flag. With the default 16384-period window, the first result appears 16384 output periods after reset.

Top module: `src_rate_detect`

## Requirements
- R1: While reset is applied and in the cycle after it, ratio_valid is 0, filt_mode is 1 and ratio_est is 0.
- R2: At the end of each window of SAMPLE_DIV * 2^WIN_LOG2 clock cycles, ratio_est equals the exact number of input word-clock rising edges seen in that window, after the two-flop synchronizer.
- R3: filt_mode is 1 (up-conversion) when the count is at most WIN*33/32, i.e. the ratio fso/fsi is at least 32/33. filt_mode only takes values 1 to 6.
- R4: filt_mode is 2 when WIN*33/32 < count <= WIN*37/32.
- R5: filt_mode is 3 when WIN*37/32 < count <= WIN*45/32.
- R6: filt_mode is 4 when WIN*45/32 < count <= WIN*51/32.
- R7: filt_mode is 5 when WIN*51/32 < count < WIN*65/32.
- R8: filt_mode is 6 when the count is at least WIN*65/32, i.e. the ratio is 32/65 or below.
- R9: ratio_est and filt_mode change only in the cycle after a window ends. They hold their values through the rest of the window.
- R10: ratio_valid rises only at the end of the first complete window after reset and then stays high. Every following window replaces the outputs with a fresh measurement.
- R11: A reset applied part-way through a window clears ratio_valid and discards the partial count. The next result comes from a full window that starts at reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, SAMPLE_DIV times the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| word_clk_in | input | 1 | Input word clock, asynchronous to clk |
| ratio_est | output | WIN_LOG2+3 | Edge count of the last window (fsi/fso with WIN_LOG2 fraction bits) |
| filt_mode | output | 3 | Selected anti-aliasing filter mode, 1 to 6 |
| ratio_valid | output | 1 | A complete measurement window has finished since reset |

## Verification
The assertions check the following on every cycle:
- the outputs hold steady except right after a window boundary;
- the valid flag only rises at a boundary and never drops without reset;
- the mode stays in its legal range;
- the synchronizer produces single-cycle edge pulses;
- the window timer wraps correctly.

The exact edge count and the choice of mode on each side of all five limits can only be shown by the bench scenarios. These scenarios place a known number of word-clock edges inside a window. Resets in the middle of a window and back-to-back windows that change mode are also covered by scenarios.

// File: rtl/src_rate_pkg.sv
package src_rate_pkg;

    typedef enum logic [2:0] {
        FM_UP  = 3'd1,
        FM_DN1 = 3'd2,
        FM_DN2 = 3'd3,
        FM_DN3 = 3'd4,
        FM_DN4 = 3'd5,
        FM_DN5 = 3'd6
    } filt_mode_e;

    typedef struct packed {
        logic       valid;
        filt_mode_e mode;
    } sel_state_t;

    localparam int unsigned NUM_LIMITS = 5;

    // Window length divided by the threshold 32/den gives win*den/32 edges.
    function automatic int unsigned mode_limit(int unsigned win, int unsigned idx);
        int unsigned den;
        case (idx)
            0:       den = 33;
            1:       den = 37;
            2:       den = 45;
            3:       den = 51;
            default: den = 65;
        endcase
        return (win * den) / 32;
    endfunction

endpackage

// File: rtl/src_edge_sync.sv
module src_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i <= SYNC_STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    p_rise_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/src_window_timer.sv
module src_window_timer #(
    parameter int unsigned WIN_CLKS = 512 * 16384
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int TW = $clog2(WIN_CLKS);

    logic [TW-1:0] tick_q;

    assign win_end = (tick_q == TW'(WIN_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || win_end) tick_q <= '0;
        else                tick_q <= tick_q + 1'b1;
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (tick_q == '0));

endmodule

// File: rtl/src_mode_classify.sv
module src_mode_classify
    import src_rate_pkg::*;
#(
    parameter int unsigned WIN = 16384,
    parameter int          CW  = 17
) (
    input  logic [CW-1:0] count,
    output filt_mode_e    mode
);
    logic [NUM_LIMITS-1:0] over;

    for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_lim
        localparam int unsigned LIM = mode_limit(WIN, g);
        if (g == NUM_LIMITS - 1) begin : g_incl
            assign over[g] = (32'(count) >= LIM);
        end else begin : g_excl
            assign over[g] = (32'(count) > LIM);
        end
    end

    logic [2:0] mode_val;
    always_comb begin
        mode_val = 3'd1;
        for (int i = 0; i < NUM_LIMITS; i++) begin
            mode_val = mode_val + {2'b00, over[i]};
        end
    end

    assign mode = filt_mode_e'(mode_val);

endmodule

// File: rtl/src_rate_detect.sv
module src_rate_detect
    import src_rate_pkg::*;
#(
    parameter int SAMPLE_DIV  = 512,
    parameter int WIN_LOG2    = 14,
    parameter int SYNC_STAGES = 2,
    localparam int RATIO_W    = WIN_LOG2 + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               word_clk_in,
    output logic [RATIO_W-1:0] ratio_est,
    output logic [2:0]         filt_mode,
    output logic               ratio_valid
);
    localparam int unsigned WIN      = 1 << WIN_LOG2;
    localparam int unsigned WIN_CLKS = SAMPLE_DIV * WIN;

    logic               rise;
    logic               win_end;
    logic [RATIO_W-1:0] run_cnt;
    logic [RATIO_W-1:0] next_cnt;
    filt_mode_e         next_mode;
    sel_state_t         sel_q;

    src_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .async_in(word_clk_in), .rise(rise)
    );

    src_window_timer #(.WIN_CLKS(WIN_CLKS)) timer_i (
        .clk(clk), .rst(rst), .win_end(win_end)
    );

    // Saturating add of this cycle's edge.
    assign next_cnt = (rise && (run_cnt != '1)) ? run_cnt + 1'b1 : run_cnt;

    src_mode_classify #(.WIN(WIN), .CW(RATIO_W)) cls_i (
        .count(next_cnt), .mode(next_mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt   <= '0;
            ratio_est <= '0;
            sel_q     <= '{valid: 1'b0, mode: FM_UP};
        end else if (win_end) begin
            run_cnt   <= '0;
            ratio_est <= next_cnt;
            sel_q     <= '{valid: 1'b1, mode: next_mode};
        end else begin
            run_cnt   <= next_cnt;
        end
    end

    assign filt_mode   = sel_q.mode;
    assign ratio_valid = sel_q.valid;

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> ($stable(filt_mode) && $stable(ratio_est)));

    p_valid_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ratio_valid |=> ratio_valid);

    p_valid_at_edge_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ratio_valid) |-> $past(win_end));

    p_mode_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (filt_mode >= 3'd1) && (filt_mode <= 3'd6));

    p_count_grows_r2: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> (run_cnt >= $past(run_cnt)));

endmodule

// File: tb/src_rate_detect_tb_top.sv
module src_rate_detect_tb_top;

    localparam int SAMPLE_DIV = 32;
    localparam int WIN_LOG2   = 8;
    localparam int RATIO_W    = WIN_LOG2 + 3;
    localparam int WIN_CLKS   = SAMPLE_DIV * (1 << WIN_LOG2);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               word_clk_in = 1'b0;
    logic [RATIO_W-1:0] ratio_est;
    logic [2:0]         filt_mode;
    logic               ratio_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    src_rate_detect #(.SAMPLE_DIV(SAMPLE_DIV), .WIN_LOG2(WIN_LOG2)) dut_i (
        .clk(clk), .rst(rst), .word_clk_in(word_clk_in),
        .ratio_est(ratio_est), .filt_mode(filt_mode), .ratio_valid(ratio_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        word_clk_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One window: n edges spaced evenly, first pulse 4 cycles in.
    // At j = WIN_CLKS-2 the outputs must still hold prev values.
    task automatic run_window(input int n, input int pre_valid,
                              input int pre_mode, input string req);
        int s;
        s = WIN_CLKS / n;
        for (int j = 0; j < WIN_CLKS; j++) begin
            @(negedge clk);
            word_clk_in = (j >= 4) && (((j - 4) % s) < 4) && (((j - 4) / s) < n);
            if (j == WIN_CLKS - 2) begin
                check(ratio_valid == pre_valid[0], req, ratio_valid, pre_valid);
                check(filt_mode == pre_mode[2:0], req, filt_mode, pre_mode);
            end
        end
        word_clk_in = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(ratio_valid == 1'b0, "R1", ratio_valid, 0);
        check(filt_mode == 3'd1, "R1", filt_mode, 1);
        check(ratio_est == '0, "R1", ratio_est, 0);
    endtask

    task automatic t_first_window();
        do_reset();
        run_window(256, 0, 1, "R10");
        check(ratio_valid == 1'b1, "R10", ratio_valid, 1);
        check(ratio_est == RATIO_W'(256), "R2", ratio_est, 256);
        check(filt_mode == 3'd1, "R3", filt_mode, 1);
    endtask

    task automatic t_measure(input int n, input int exp_mode, input string req);
        do_reset();
        run_window(n, 0, 1, "R9");
        check(ratio_est == RATIO_W'(n), "R2", ratio_est, n);
        check(filt_mode == exp_mode[2:0], req, filt_mode, exp_mode);
    endtask

    task automatic t_continuous();
        // Follows t_first_window's result of mode 1 without reset.
        run_window(409, 1, 1, "R9");
        check(filt_mode == 3'd5, "R10", filt_mode, 5);
        check(ratio_est == RATIO_W'(409), "R10", ratio_est, 409);
    endtask

    task automatic t_reset_mid();
        do_reset();
        for (int j = 0; j < WIN_CLKS / 2; j++) begin
            @(negedge clk);
            word_clk_in = (j % 16) < 4;
        end
        do_reset();
        @(negedge clk);
        check(ratio_valid == 1'b0, "R11", ratio_valid, 0);
        check(ratio_est == '0, "R11", ratio_est, 0);
        do_reset();
        run_window(300, 0, 1, "R11");
        check(ratio_valid == 1'b1, "R11", ratio_valid, 1);
        check(ratio_est == RATIO_W'(300), "R11", ratio_est, 300);
        check(filt_mode == 3'd3, "R11", filt_mode, 3);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_first_window();
        t_continuous();
        t_measure(200, 1, "R3");
        t_measure(264, 1, "R3");
        t_measure(265, 2, "R4");
        t_measure(296, 2, "R4");
        t_measure(297, 3, "R5");
        t_measure(360, 3, "R5");
        t_measure(361, 4, "R6");
        t_measure(408, 4, "R6");
        t_measure(409, 5, "R7");
        t_measure(519, 5, "R7");
        t_measure(520, 6, "R8");
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule